// File: doc/BRIEF.md
# Oversampled Serial Receiver with Address-Match Interrupts

This block receives asynchronous serial characters and turns them into parallel words. The line is oversampled at sixteen times the bit rate, and every bit is taken at its middle. A frame has one start bit, five to eight data bits sent least significant bit first, an optional ninth bit, and one stop bit. When the stop bit has been sampled, the valid data bits go into a receive buffer, and all receive flags are updated in that same cycle.

The ninth bit can mark a word as an address. A two-bit selector picks one of four conditions that raise the address flag. These conditions combine the ninth bit, an equality test against a programmable compare byte, and whether the word is the first one after a line break. With the equality test on its own, the block searches for a fixed character such as an end-of-block code. A break is a line held low for a whole frame. It sets its own flag and loads no data.

For channel testing, the receiver input can come from the local transmitter line instead of the pin (loop-back). The output pin can also repeat the input pin (auto-echo). The two modes can be used separately or together.

Top module: `serial_addr_rx`

## Requirements
- R1: One bit time lasts 16*(baud_div+1) clock cycles. A frame is a low start bit, then data bits least significant first, then the ninth bit when ninth_en=1, then a stop bit. The number of data bits is set by word_len: 00=5, 01=6, 10=7, 11=8. After a frame whose stop bit is high, rd_data holds the word and rx_ready is 1.
- R2: For words shorter than 8 bits, every bit of rd_data above the word length reads as 1.
- R3: rd_ninth holds the received ninth bit when ninth_en=1, and reads 0 when ninth_en=0.
- R4: At each buffer load, addr_flag is set when the condition picked by addr_mode holds. The codes are: 00 = ninth bit is 1; 01 = rd_data equals cmp_value; 10 = equality and ninth bit 1; 11 = equality and the word is the first complete word after a break. If the condition does not hold, addr_flag is left as it was.
- R5: The "after break" state is set by a break and cleared by the next complete word, whether or not that word matches.
- R6: If every sampled bit of a frame is 0, including the stop position, brk_flag is set. In that case rx_ready and rd_data are left unchanged, and no new start is searched for until the line returns high.
- R7: If the line is no longer low at the middle of the start bit, the start is dropped and no word is received.
- R8: A one-cycle rd_en pulse clears rx_ready, addr_flag and brk_flag.
- R9: With echo_en=1, ser_out equals ser_in one clock later.
- R10: With loop_en=1, the receiver takes its input from tx_in. With loop_en=1 and echo_en=0, ser_out is held at 1. With both modes off, ser_out follows tx_in one clock later.
- R11: After reset, rx_ready, addr_flag and brk_flag are 0, rd_data is 8'hFF, rd_ninth is 0 and ser_out is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial input pin |
| tx_in | input | 1 | Local transmitter line |
| ser_out | output | 1 | Serial output pin (transmitter, echo or idle) |
| baud_div | input | 16 | Oversample tick period minus one, in clocks |
| word_len | input | 2 | Data length code (5 to 8 bits) |
| ninth_en | input | 1 | Frames carry a ninth bit |
| addr_mode | input | 2 | Address-flag condition selector |
| cmp_value | input | 8 | Address/character compare value |
| echo_en | input | 1 | Auto-echo enable |
| loop_en | input | 1 | Loop-back enable |
| rd_en | input | 1 | Buffer read strobe; clears the flags |
| rd_data | output | 8 | Receive buffer, with unused upper bits set to 1 |
| rd_ninth | output | 1 | Received ninth bit |
| rx_ready | output | 1 | A word has been loaded |
| addr_flag | output | 1 | Address condition met |
| brk_flag | output | 1 | Line break received |

## Verification
The hardest situation to reach is mode 11. It needs a break frame, then a matching word, then a second matching word, and only the first of those two words may raise the address flag. The bench builds this sequence on purpose. It also keeps its own model of the after-break state through a long random run, which mixes word lengths, ninth-bit settings, modes and compare values (half of the compare values are forced to equal the word). A directed sequence also sends a start glitch shorter than half a bit, to check that the start is rejected.

// File: rtl/serial_addr_rx_pkg.sv
package serial_addr_rx_pkg;
  typedef enum logic [2:0] {
    RX_IDLE  = 3'd0,
    RX_START = 3'd1,
    RX_BITS  = 3'd2,
    RX_STOP  = 3'd3,
    RX_HOLD  = 3'd4
  } rx_state_e;

  typedef enum logic [1:0] {
    AM_NINTH       = 2'b00,
    AM_MATCH       = 2'b01,
    AM_MATCH_NINTH = 2'b10,
    AM_AFTER_BREAK = 2'b11
  } addr_mode_e;
endpackage

// File: rtl/rx_line_sync.sv
module rx_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic line_i,
  output logic line_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) chain_q <= '1;
    else     chain_q <= {chain_q[STAGES-2:0], line_i};
  end

  assign line_o = chain_q[STAGES-1];
endmodule

// File: rtl/rx_os_tick.sv
module rx_os_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] div_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt_q;
  logic             hit;

  assign hit = (cnt_q >= div_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      cnt_q  <= hit ? '0 : cnt_q + 1'b1;
      tick_o <= hit;
    end
  end
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import serial_addr_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int OS_RATE = 16,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             line_i,
  input  logic [LEN_W-1:0] word_len_i,
  input  logic             ninth_en_i,
  output logic             load_o,
  output logic             brk_o,
  output logic [DATA_W:0]  bits_o
);
  localparam int OS_W  = $clog2(OS_RATE);
  localparam int IDX_W = $clog2(DATA_W + 2);
  localparam logic [OS_W-1:0] MID_CNT  = OS_W'(OS_RATE / 2 - 1);
  localparam logic [OS_W-1:0] FULL_CNT = OS_W'(OS_RATE - 1);

  rx_state_e         st_q;
  logic [OS_W-1:0]   os_q;
  logic [IDX_W-1:0]  idx_q;
  logic [IDX_W-1:0]  last_idx;
  logic [DATA_W:0]   sh_q;
  logic              zeros_q;
  logic              at_mid, at_full;

  assign last_idx = IDX_W'(MIN_LEN - 1) + IDX_W'(word_len_i) + IDX_W'(ninth_en_i);
  assign at_mid   = tick_i && (os_q == MID_CNT);
  assign at_full  = tick_i && (os_q == FULL_CNT);
  assign bits_o   = sh_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= RX_IDLE;
      os_q    <= '0;
      idx_q   <= '0;
      sh_q    <= '0;
      zeros_q <= 1'b1;
      load_o  <= 1'b0;
      brk_o   <= 1'b0;
    end else begin
      load_o <= 1'b0;
      brk_o  <= 1'b0;
      unique case (st_q)
        RX_IDLE: begin
          os_q <= '0;
          if (!line_i) st_q <= RX_START;
        end
        RX_START: begin
          if (at_mid) begin
            os_q <= '0;
            if (line_i) begin
              st_q <= RX_IDLE;
            end else begin
              st_q    <= RX_BITS;
              idx_q   <= '0;
              sh_q    <= '0;
              zeros_q <= 1'b1;
            end
          end else if (tick_i) begin
            os_q <= os_q + 1'b1;
          end
        end
        RX_BITS: begin
          if (at_full) begin
            os_q        <= '0;
            sh_q[idx_q] <= line_i;
            zeros_q     <= zeros_q & ~line_i;
            idx_q       <= idx_q + 1'b1;
            if (idx_q == last_idx) st_q <= RX_STOP;
          end else if (tick_i) begin
            os_q <= os_q + 1'b1;
          end
        end
        RX_STOP: begin
          if (at_full) begin
            os_q <= '0;
            if (zeros_q && !line_i) begin
              brk_o <= 1'b1;
              st_q  <= RX_HOLD;
            end else begin
              load_o <= 1'b1;
              st_q   <= line_i ? RX_IDLE : RX_HOLD;
            end
          end else if (tick_i) begin
            os_q <= os_q + 1'b1;
          end
        end
        RX_HOLD: begin
          if (line_i) st_q <= RX_IDLE;
        end
        default: st_q <= RX_IDLE;
      endcase
    end
  end

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    load_o |=> !load_o); // R1
  AST_BRK_WAITS_HIGH: assert property (@(posedge clk) disable iff (rst)
    brk_o |-> (st_q == RX_HOLD)); // R6
endmodule

// File: rtl/rx_buffer.sv
module rx_buffer
  import serial_addr_rx_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int MIN_LEN = 5,
  parameter int LEN_W   = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic              brk_i,
  input  logic [DATA_W:0]   bits_i,
  input  logic [LEN_W-1:0]  word_len_i,
  input  logic              ninth_en_i,
  input  logic [1:0]        mode_i,
  input  logic [DATA_W-1:0] cmp_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_ninth_o,
  output logic              ready_o,
  output logic              addr_o,
  output logic              brk_flag_o
);
  localparam int IDX_W = $clog2(DATA_W + 2);

  logic [DATA_W-1:0] word_c;
  logic [IDX_W-1:0]  ninth_idx;
  logic              ninth_c;
  logic              match_c;
  logic              hit_c;
  logic              after_brk_q;

  for (genvar i = 0; i < DATA_W; i++) begin : g_fill
    assign word_c[i] = (i < MIN_LEN + int'(word_len_i)) ? bits_i[i] : 1'b1;
  end

  assign ninth_idx = IDX_W'(MIN_LEN) + IDX_W'(word_len_i);
  assign ninth_c   = ninth_en_i & bits_i[ninth_idx];
  assign match_c   = (word_c == cmp_i);

  always_comb begin
    unique case (addr_mode_e'(mode_i))
      AM_NINTH:       hit_c = ninth_c;
      AM_MATCH:       hit_c = match_c;
      AM_MATCH_NINTH: hit_c = match_c & ninth_c;
      AM_AFTER_BREAK: hit_c = match_c & after_brk_q;
      default:        hit_c = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o   <= '1;
      rd_ninth_o  <= 1'b0;
      ready_o     <= 1'b0;
      addr_o      <= 1'b0;
      brk_flag_o  <= 1'b0;
      after_brk_q <= 1'b0;
    end else begin
      if (load_i) begin
        rd_data_o  <= word_c;
        rd_ninth_o <= ninth_c;
      end
      if (brk_i)       after_brk_q <= 1'b1;
      else if (load_i) after_brk_q <= 1'b0;

      if (load_i)       ready_o <= 1'b1;
      else if (rd_en_i) ready_o <= 1'b0;

      if (load_i && hit_c) addr_o <= 1'b1;
      else if (rd_en_i)    addr_o <= 1'b0;

      if (brk_i)        brk_flag_o <= 1'b1;
      else if (rd_en_i) brk_flag_o <= 1'b0;
    end
  end

  AST_READY_ON_LOAD: assert property (@(posedge clk) disable iff (rst)
    load_i |=> ready_o); // R1
  AST_ADDR_AT_LOAD: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_o) |-> $past(load_i)); // R4
  AST_AFTER_BRK_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (load_i && !brk_i) |=> !after_brk_q); // R5
  AST_BRK_KEEPS_DATA: assert property (@(posedge clk) disable iff (rst)
    (brk_i && !load_i) |=> $stable(rd_data_o)); // R6
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (rd_en_i && !load_i && !brk_i) |=> (!ready_o && !brk_flag_o)); // R8
endmodule

// File: rtl/serial_addr_rx.sv
module serial_addr_rx
  import serial_addr_rx_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int DIV_W       = 16,
  parameter int OS_RATE     = 16,
  parameter int MIN_LEN     = 5,
  parameter int LEN_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ser_in,
  input  logic              tx_in,
  output logic              ser_out,
  input  logic [DIV_W-1:0]  baud_div,
  input  logic [LEN_W-1:0]  word_len,
  input  logic              ninth_en,
  input  logic [1:0]        addr_mode,
  input  logic [DATA_W-1:0] cmp_value,
  input  logic              echo_en,
  input  logic              loop_en,
  input  logic              rd_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_ninth,
  output logic              rx_ready,
  output logic              addr_flag,
  output logic              brk_flag
);
  logic             rx_raw, rx_s, tick;
  logic             load, brk;
  logic [DATA_W:0]  bits;

  assign rx_raw = loop_en ? tx_in : ser_in;

  always_ff @(posedge clk) begin
    if (rst)          ser_out <= 1'b1;
    else if (echo_en) ser_out <= ser_in;
    else if (loop_en) ser_out <= 1'b1;
    else              ser_out <= tx_in;
  end

  rx_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .line_i(rx_raw), .line_o(rx_s)
  );

  rx_os_tick #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst(rst), .div_i(baud_div), .tick_o(tick)
  );

  rx_framer #(.DATA_W(DATA_W), .OS_RATE(OS_RATE), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_framer (
    .clk(clk), .rst(rst), .tick_i(tick), .line_i(rx_s),
    .word_len_i(word_len), .ninth_en_i(ninth_en),
    .load_o(load), .brk_o(brk), .bits_o(bits)
  );

  rx_buffer #(.DATA_W(DATA_W), .MIN_LEN(MIN_LEN), .LEN_W(LEN_W)) u_buffer (
    .clk(clk), .rst(rst), .load_i(load), .brk_i(brk), .bits_i(bits),
    .word_len_i(word_len), .ninth_en_i(ninth_en), .mode_i(addr_mode),
    .cmp_i(cmp_value), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .rd_ninth_o(rd_ninth), .ready_o(rx_ready),
    .addr_o(addr_flag), .brk_flag_o(brk_flag)
  );

  AST_ECHO_PATH: assert property (@(posedge clk) disable iff (rst)
    echo_en |=> (ser_out == $past(ser_in))); // R9
  AST_LOOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (loop_en && !echo_en) |=> ser_out); // R10
endmodule

// File: tb/serial_addr_rx_tb_top.sv
module serial_addr_rx_tb_top;
  localparam int DIV = 1;
  localparam int BIT = 16 * (DIV + 1);

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ser_in = 1'b1, tx_in = 1'b1;
  logic       ser_out;
  logic [1:0] word_len = 2'b11;
  logic       ninth_en = 1'b0;
  logic [1:0] addr_mode = 2'b00;
  logic [7:0] cmp_value = 8'h00;
  logic       echo_en = 1'b0, loop_en = 1'b0, rd_en = 1'b0;
  logic [7:0] rd_data;
  logic       rd_ninth, rx_ready, addr_flag, brk_flag;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  bit  fb_model = 1'b0;

  always #2.5 clk = ~clk;

  serial_addr_rx dut_i (
    .clk(clk), .rst(rst), .ser_in(ser_in), .tx_in(tx_in), .ser_out(ser_out),
    .baud_div(16'(DIV)), .word_len(word_len), .ninth_en(ninth_en),
    .addr_mode(addr_mode), .cmp_value(cmp_value), .echo_en(echo_en),
    .loop_en(loop_en), .rd_en(rd_en), .rd_data(rd_data), .rd_ninth(rd_ninth),
    .rx_ready(rx_ready), .addr_flag(addr_flag), .brk_flag(brk_flag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_word(input logic [7:0] w, input int len);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = (i < len) ? w[i] : 1'b1;
    return r;
  endfunction

  function automatic bit exp_hit(input logic [1:0] m, input logic [7:0] d,
                                 input logic [7:0] c, input bit n, input bit fb);
    bit eq;
    eq = (d == c);
    case (m)
      2'b00:   return n;
      2'b01:   return eq;
      2'b10:   return eq && n;
      default: return eq && fb;
    endcase
  endfunction

  task automatic drive(input bit v, input bit on_tx, input int clocks);
    @(negedge clk);
    if (on_tx) tx_in = v; else ser_in = v;
    repeat (clocks - 1) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] w, input int len, input bit use9,
                      input bit n9, input bit on_tx);
    drive(1'b0, on_tx, BIT);
    for (int i = 0; i < len; i++) drive(w[i], on_tx, BIT);
    if (use9) drive(n9, on_tx, BIT);
    drive(1'b1, on_tx, BIT);
    drive(1'b1, on_tx, 4);
  endtask

  task automatic do_read();
    @(negedge clk); rd_en = 1'b1;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic frame_check(input logic [7:0] w, input int len, input bit use9,
                             input bit n9, input bit on_tx, input string req);
    logic [7:0] ed;
    bit         en, eh;
    do_read();
    send(w, len, use9, n9, on_tx);
    ed = exp_word(w, len);
    en = use9 && n9;
    eh = exp_hit(addr_mode, ed, cmp_value, en, fb_model);
    fb_model = 1'b0;
    chk(rx_ready == 1'b1, req, "rx_ready", int'(rx_ready), 1);
    chk(rd_data == ed, req, "rd_data", int'(rd_data), int'(ed));
    chk(rd_ninth == en, "R3", "rd_ninth", int'(rd_ninth), int'(en));
    chk(addr_flag == eh, "R4", "addr_flag", int'(addr_flag), int'(eh));
  endtask

  task automatic send_break(input int total_bits);
    drive(1'b0, 1'b0, BIT * (total_bits + 2));
    drive(1'b1, 1'b0, BIT);
    fb_model = 1'b1;
  endtask

  initial begin : watchdog
    repeat (180000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R1 watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    logic [7:0] w, prev;
    int         len;
    void'($urandom(32'd5151));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    chk(rx_ready == 0 && addr_flag == 0 && brk_flag == 0, "R11", "flags",
        {rx_ready, addr_flag, brk_flag}, 0);
    chk(rd_data == 8'hFF, "R11", "rd_data", int'(rd_data), 8'hFF);
    chk(rd_ninth == 0 && ser_out == 1, "R11", "ninth/out", {rd_ninth, ser_out}, 1);

    // R1 full 8-bit word
    word_len = 2'b11; addr_mode = 2'b01; cmp_value = 8'h0D;
    frame_check(8'hA5, 8, 0, 0, 0, "R1");
    // R4 character search for 0x0D
    frame_check(8'h0D, 8, 0, 0, 0, "R4");
    // R2 five-bit word
    word_len = 2'b00; addr_mode = 2'b00;
    frame_check(8'h0A, 5, 0, 0, 0, "R2");
    // R3 ninth bit as address marker
    word_len = 2'b10; ninth_en = 1'b1;
    frame_check(8'h33, 7, 1, 1, 0, "R3");

    // R8 read clears flags
    do_read();
    chk(!rx_ready && !addr_flag && !brk_flag, "R8", "flags after read",
        {rx_ready, addr_flag, brk_flag}, 0);

    // R6 break: no load, data kept
    word_len = 2'b11; ninth_en = 1'b0; prev = rd_data;
    send_break(10);
    chk(brk_flag == 1'b1, "R6", "brk_flag", int'(brk_flag), 1);
    chk(rx_ready == 1'b0, "R6", "rx_ready after break", int'(rx_ready), 0);
    chk(rd_data == prev, "R6", "rd_data kept", int'(rd_data), int'(prev));

    // R5 mode 11: first match after break hits, second does not
    addr_mode = 2'b11; cmp_value = 8'h17;
    frame_check(8'h17, 8, 0, 0, 0, "R5");
    frame_check(8'h17, 8, 0, 0, 0, "R5");
    // break then non-matching word, then matching word: no hit
    do_read();
    send_break(10);
    frame_check(8'h42, 8, 0, 0, 0, "R5");
    frame_check(8'h17, 8, 0, 0, 0, "R5");

    // R7 start glitch rejected
    do_read();
    drive(1'b0, 1'b0, 4 * (DIV + 1));
    drive(1'b1, 1'b0, BIT * 12);
    chk(rx_ready == 1'b0, "R7", "rx_ready after glitch", int'(rx_ready), 0);

    // R9 echo
    echo_en = 1'b1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk); ser_in = i[0];
      @(negedge clk);
      chk(ser_out == ser_in, "R9", "echo", int'(ser_out), int'(ser_in));
    end
    @(negedge clk); ser_in = 1'b1; echo_en = 1'b0;

    // R10 loop-back: receiver fed from tx_in, ser_out quiet
    loop_en = 1'b1; addr_mode = 2'b01; cmp_value = 8'h00;
    frame_check(8'h6C, 8, 0, 0, 1, "R10");
    chk(ser_out == 1'b1, "R10", "ser_out in loop", int'(ser_out), 1);
    // both modes: pin echoes, receiver still on tx_in
    echo_en = 1'b1;
    @(negedge clk); ser_in = 1'b0;
    @(negedge clk);
    chk(ser_out == 1'b0, "R10", "echo with loop", int'(ser_out), 0);
    frame_check(8'h91, 8, 0, 0, 1, "R10");
    @(negedge clk); ser_in = 1'b1; echo_en = 1'b0; loop_en = 1'b0;
    @(negedge clk); tx_in = 1'b0;
    @(negedge clk);
    chk(ser_out == 1'b0, "R10", "tx passthrough", int'(ser_out), 0);
    @(negedge clk); tx_in = 1'b1;

    // random frames, R1 R2 R3 R4
    for (int k = 0; k < 30; k++) begin
      word_len  = 2'($urandom_range(0, 3));
      ninth_en  = 1'($urandom_range(0, 1));
      addr_mode = 2'($urandom_range(0, 3));
      len = 5 + int'(word_len);
      w = 8'($urandom);
      cmp_value = ($urandom_range(0, 1) != 0) ? exp_word(w, len) : 8'($urandom);
      if (k % 7 == 3) begin
        do_read();
        send_break(len + int'(ninth_en) + 1);
        chk(brk_flag == 1'b1, "R6", "random break", int'(brk_flag), 1);
      end
      frame_check(w, len, ninth_en, 1'($urandom_range(0, 1)), 0, "R1");
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule